// File: doc/BRIEF.md
# Basic Up-Counting Timer with Update Event

This block is a 16-bit up-counter driven through a prescaler and controlled over a small synchronous register bus. While running, the counter advances once every (divider + 1) clock cycles. When it reaches a programmable top value on a counting tick, it wraps to zero and raises an overflow. Software can also force an update. A forced update returns both the counter and the prescaler count to zero but keeps the division ratio.

Overflows and forced updates are two separate sources of the update event, and each has its own gating. Both are blocked by an inhibit bit. Forced updates can also be kept away from the flag by a source-select bit. The flag is sticky. It drives an interrupt request when the interrupt enable is set, and a copy of it is returned in the top bit of every counter read. Software clears the flag by writing zero to it.

Top module: `basic_update_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `bus_rdata` is 0.
- R2: With the run bit (control bit 0) at 1, the counter advances once every DIV+1 clock cycles, where DIV is the divider register. With the run bit at 0, the counter and the prescaler count hold their values.
- R3: When the counter equals the top value on a counting tick, the counter goes to 0 on that tick and an overflow occurs.
- R4: An overflow sets the flag (status bit 0) only while the inhibit bit (control bit 1) is 0.
- R5: Writing 1 to bit 0 of the event register (0x14) sets the counter and the prescaler count to 0, and the divider value does not change. Writing 0 to it has no effect, and the event register always reads 0.
- R6: A forced update sets the flag only when both the source-select bit (control bit 2) and the inhibit bit are 0.
- R7: Writing the status register (0x10) with bit 0 = 0 clears the flag, and writing it with bit 0 = 1 has no effect. Status bits 31:1 read 0. When a set and a clear of the flag fall in the same cycle, the flag ends up set.
- R8: The counter register (0x24) gives read/write access to the counter in bits 15:0. Bit 31 returns the flag and ignores writes, and bits 30:16 read 0.
- R9: `irq` is 1 exactly while the flag is 1 and the interrupt-enable bit (bit 0 of 0x0C) is 1.
- R10: The register map is: control 0x00 (bits 2:0), interrupt enable 0x0C (bit 0), status 0x10, event 0x14, counter 0x24, divider 0x28 (bits 15:0) and top value 0x2C (bits 15:0). Unlisted offsets read 0. Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.
- R11: In one cycle, a forced update takes priority over a counter write, and a counter write takes priority over a counting tick. A tick that coincides with either of them produces no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Update interrupt request |

## Verification
A prescaler count that has gone wrong shows up as a counter value that is off by one tick in a counter read, and it does so within DIV+1 cycles of running. A wrong counter or top-value state causes an overflow on the wrong tick, which sets the flag early or late. That error reaches `irq` in the same cycle, and a status or counter read shows it one cycle later. Broken flag gating or clear priority leaves `irq` different from the expected level straight after the event or the clearing write. For that reason the bench compares `irq` and `bus_rdata` in every cycle against a reference model.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;

  // register offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_SR     = 8'h10;
  localparam logic [7:0] OFS_EGR    = 8'h14;
  localparam logic [7:0] OFS_CNT    = 8'h24;
  localparam logic [7:0] OFS_DIV    = 8'h28;
  localparam logic [7:0] OFS_RELOAD = 8'h2C;

  // control bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_UDIS = 1;
  localparam int unsigned CB_URS  = 2;

  typedef struct packed {
    logic urs;
    logic udis;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
  import upd_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic              ien,
  output logic [CNT_W-1:0]  div,
  output logic [CNT_W-1:0]  reload,
  output logic              sw_update,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              flag_clr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic              wr_acc, rd_acc;
  logic              hit_ctrl, hit_ien, hit_sr, hit_egr, hit_cnt, hit_div, hit_rel;
  logic              ctrl_en, ien_en, div_en, rel_en;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic [CNT_W-1:0]  div_q, div_d, rel_q, rel_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rview;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  // address decode
  always_comb begin
    wr_acc   = bus_sel & bus_wr;
    rd_acc   = bus_sel & ~bus_wr;
    hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    hit_ien  = (bus_addr == ADDR_W'(OFS_IEN));
    hit_sr   = (bus_addr == ADDR_W'(OFS_SR));
    hit_egr  = (bus_addr == ADDR_W'(OFS_EGR));
    hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
    hit_div  = (bus_addr == ADDR_W'(OFS_DIV));
    hit_rel  = (bus_addr == ADDR_W'(OFS_RELOAD));
  end

  // write strobes and next values
  always_comb begin
    ctrl_en   = wr_acc & hit_ctrl;
    ien_en    = wr_acc & hit_ien;
    div_en    = wr_acc & hit_div;
    rel_en    = wr_acc & hit_rel;
    ctrl_d    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    ien_d     = bus_wdata[0];
    div_d     = bus_wdata[CNT_W-1:0];
    rel_d     = bus_wdata[CNT_W-1:0];
    sw_update = wr_acc & hit_egr & bus_wdata[0];
    cnt_wr    = wr_acc & hit_cnt;
    cnt_wdata = bus_wdata[CNT_W-1:0];
    flag_clr  = wr_acc & hit_sr & ~bus_wdata[0];
  end

  // read view
  always_comb begin
    rview = '0;
    unique case (1'b1)
      hit_ctrl: rview[CTRL_W-1:0] = ctrl_q;
      hit_ien:  rview[0]          = ien_q;
      hit_sr:   rview[0]          = flag;
      hit_cnt: begin
        rview[CNT_W-1:0]  = cnt;
        rview[DATA_W-1]   = flag;
      end
      hit_div:  rview[CNT_W-1:0]  = div_q;
      hit_rel:  rview[CNT_W-1:0]  = rel_q;
      default:  rview             = '0;
    endcase
    rdata_d = rview;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= 1'b0;
      div_q   <= '0;
      rel_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q  <= ctrl_d;
      if (ien_en)  ien_q   <= ien_d;
      if (div_en)  div_q   <= div_d;
      if (rel_en)  rel_q   <= rel_d;
      if (rd_acc)  rdata_q <= rdata_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign ien       = ien_q;
  assign div       = div_q;
  assign reload    = rel_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/upd_timer_prescaler.sv
module upd_timer_prescaler #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] div,
  output logic             tick,
  output logic [CNT_W-1:0] psc
);

  logic [CNT_W-1:0] psc_q, psc_d;
  logic             psc_en;
  logic             at_ratio;

  always_comb begin
    at_ratio = (psc_q == div);
    tick     = run & at_ratio;
    psc_en   = clr | run;
    if (clr)
      psc_d = '0;
    else if (at_ratio)
      psc_d = '0;
    else
      psc_d = psc_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      psc_q <= '0;
    else if (psc_en)
      psc_q <= psc_d;
  end

  assign psc = psc_q;

endmodule

// File: rtl/upd_timer_counter.sv
module upd_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sw_update,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == reload);
    ovf    = tick & ~sw_update & ~wr_en & at_top;
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (sw_update) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (wr_en) begin
      cnt_en = 1'b1;
      cnt_d  = wr_val;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = at_top ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/upd_timer_flag.sv
module upd_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic sw_update,
  input  logic udis,
  input  logic urs,
  input  logic clr,
  input  logic ien,
  output logic flag,
  output logic irq
);

  logic flag_q, flag_d;
  logic set_hw, set_sw, flag_en;

  always_comb begin
    set_hw  = ovf & ~udis;
    set_sw  = sw_update & ~udis & ~urs;
    flag_en = set_hw | set_sw | clr;
    flag_d  = set_hw | set_sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_en)
      flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q & ien;

endmodule

// File: rtl/basic_update_timer.sv
module basic_update_timer
  import upd_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;
  ctrl_t                  ctrl_val;
  logic                   cfg_run, cfg_udis, cfg_urs;
  logic                   ien_val;
  logic [CNT_W-1:0]       div_val, reload_val, cnt_val, psc_val, cnt_wdata;
  logic                   sw_update, cnt_wr, flag_clr;
  logic                   tick, ovf, flag_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  assign cfg_run  = ctrl_val.run;
  assign cfg_udis = ctrl_val.udis;
  assign cfg_urs  = ctrl_val.urs;

  upd_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_val),
    .flag      (flag_val),
    .ctrl      (ctrl_val),
    .ien       (ien_val),
    .div       (div_val),
    .reload    (reload_val),
    .sw_update (sw_update),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  upd_timer_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (cfg_run),
    .clr   (sw_update),
    .div   (div_val),
    .tick  (tick),
    .psc   (psc_val)
  );

  upd_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick),
    .sw_update (sw_update),
    .wr_en     (cnt_wr),
    .wr_val    (cnt_wdata),
    .reload    (reload_val),
    .cnt       (cnt_val),
    .ovf       (ovf)
  );

  upd_timer_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ovf       (ovf),
    .sw_update (sw_update),
    .udis      (cfg_udis),
    .urs       (cfg_urs),
    .clr       (flag_clr),
    .ien       (ien_val),
    .flag      (flag_val),
    .irq       (irq)
  );

endmodule

// File: rtl/upd_timer_chk.sv
module upd_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ug,
  input logic             cnt_wr,
  input logic             sr_clr,
  input logic             run,
  input logic             udis,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] psc,
  input logic             flag,
  input logic             irq
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug && !cnt_wr) |=> ($stable(cnt) && $stable(psc)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ug && !cnt_wr && cnt == reload) |=> (cnt == '0));

  p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (udis && !flag) |=> !flag);

  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt == '0 && psc == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sr_clr) |=> flag);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);

endmodule

bind basic_update_timer upd_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .tick   (tick),
  .ug     (sw_update),
  .cnt_wr (cnt_wr),
  .sr_clr (flag_clr),
  .run    (cfg_run),
  .udis   (cfg_udis),
  .reload (reload_val),
  .cnt    (cnt_val),
  .psc    (psc_val),
  .flag   (flag_val),
  .irq    (irq)
);

// File: tb/basic_update_timer_bench.sv
`timescale 1ns/1ps
module basic_update_timer_bench;

  localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_SR = 8'h10, A_EGR = 8'h14,
                         A_CNT = 8'h24, A_DIV = 8'h28, A_REL = 8'h2C, A_GAP = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  basic_update_timer u_basic_update_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model from the requirements ----------------
  logic        m_run, m_udis, m_urs, m_ien, m_flag;
  logic [15:0] m_div, m_rel, m_psc, m_cnt;
  logic [31:0] m_rdata;
  logic [7:0]  m_last;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v;
    v = 32'h0;
    case (a)
      A_CTRL: v = {29'h0, m_urs, m_udis, m_run};
      A_IEN:  v = {31'h0, m_ien};
      A_SR:   v = {31'h0, m_flag};
      A_CNT:  v = {m_flag, 15'h0, m_cnt};
      A_DIV:  v = {16'h0, m_div};
      A_REL:  v = {16'h0, m_rel};
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      A_SR:  return "R7";
      A_EGR: return "R5";
      A_CNT: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic wr, ug, cw, tk, ovf, setf, clrf;
    logic [15:0] npsc, ncnt;
    if (!rst_n) begin
      m_run = 0; m_udis = 0; m_urs = 0; m_ien = 0; m_flag = 0;
      m_div = 0; m_rel = 0; m_psc = 0; m_cnt = 0; m_rdata = 0; m_last = A_GAP;
    end else begin
      wr   = bus_sel && bus_wr;
      if (bus_sel && !bus_wr) begin
        m_rdata = model_read(bus_addr);
        m_last  = bus_addr;
      end
      ug   = wr && bus_addr == A_EGR && bus_wdata[0];
      cw   = wr && bus_addr == A_CNT;
      tk   = m_run && m_psc == m_div;
      ovf  = tk && !ug && !cw && m_cnt == m_rel;
      setf = (ovf && !m_udis) || (ug && !m_udis && !m_urs);
      clrf = wr && bus_addr == A_SR && !bus_wdata[0];
      npsc = ug ? 16'h0 : (m_run ? (tk ? 16'h0 : m_psc + 16'h1) : m_psc);
      ncnt = ug ? 16'h0 : (cw ? bus_wdata[15:0] :
             (tk ? ((m_cnt == m_rel) ? 16'h0 : m_cnt + 16'h1) : m_cnt));
      m_psc  = npsc;
      m_cnt  = ncnt;
      m_flag = setf ? 1'b1 : (clrf ? 1'b0 : m_flag);
      if (wr && bus_addr == A_CTRL) {m_urs, m_udis, m_run} = bus_wdata[2:0];
      if (wr && bus_addr == A_IEN)  m_ien = bus_wdata[0];
      if (wr && bus_addr == A_DIV)  m_div = bus_wdata[15:0];
      if (wr && bus_addr == A_REL)  m_rel = bus_wdata[15:0];
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      n_cmp++;
      if (bus_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s rdata@%h actual=%h expected=%h", tag_of(m_last), m_last, bus_rdata, m_rdata);
      end
      n_cmp++;
      if (irq !== (m_flag & m_ien)) begin
        n_bad++;
        $display("FAIL R9 irq actual=%b expected=%b", irq, m_flag & m_ien);
      end
    end
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] addrs [8];
    addrs = '{A_CTRL, A_IEN, A_SR, A_EGR, A_CNT, A_DIV, A_REL, A_GAP};
    void'($urandom(32'd20240611));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1: reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    expect_reg("R1 ctrl", A_CTRL, 32'h0);
    expect_reg("R1 cnt", A_CNT, 32'h0);
    expect_reg("R1 sr", A_SR, 32'h0);
    expect_reg("R1 div", A_DIV, 32'h0);

    // R2: divider 2, top 3; 11 running edges -> 3 ticks
    bus_write(A_DIV, 32'd2);
    bus_write(A_REL, 32'd3);
    bus_write(A_CTRL, 32'h1);
    idle(10);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R2 count after 11 cycles", A_CNT, 32'd3);
    expect_reg("R2 no overflow yet", A_SR, 32'h0);
    idle(5);
    expect_reg("R2 holds when stopped", A_CNT, 32'd3);

    // R3/R4: one more tick wraps and sets flag
    bus_write(A_CTRL, 32'h1);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R3 wrap to zero", A_CNT, 32'h8000_0000);
    expect_reg("R4 overflow sets flag", A_SR, 32'h1);

    // R4: inhibit blocks overflow
    bus_write(A_SR, 32'h0);
    expect_reg("R7 clear by zero", A_SR, 32'h0);
    bus_write(A_REL, 32'd0);
    bus_write(A_CTRL, 32'h3);
    idle(10);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R4 inhibited overflow", A_SR, 32'h0);

    // R6: forced update gating
    bus_write(A_CTRL, 32'h4);
    bus_write(A_EGR, 32'h1);
    expect_reg("R6 source select blocks", A_SR, 32'h0);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_EGR, 32'h1);
    expect_reg("R6 forced update sets", A_SR, 32'h1);
    bus_write(A_SR, 32'h0);
    bus_write(A_CTRL, 32'h2);
    bus_write(A_EGR, 32'h1);
    expect_reg("R6 inhibit blocks", A_SR, 32'h0);
    bus_write(A_CTRL, 32'h0);

    // R5: forced update clears counter and prescaler count
    bus_write(A_REL, 32'd100);
    bus_write(A_DIV, 32'd5);
    bus_write(A_CNT, 32'd50);
    bus_write(A_CTRL, 32'h1);
    idle(2);
    bus_write(A_EGR, 32'h1);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R5 counter zeroed", A_CNT, 32'h8000_0000);
    expect_reg("R5 event reads zero", A_EGR, 32'h0);
    expect_reg("R5 ratio kept", A_DIV, 32'd5);
    bus_write(A_EGR, 32'h0);
    expect_reg("R5 zero write no effect", A_CNT, 32'h8000_0000);
    bus_write(A_CTRL, 32'h1);
    idle(3);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R5 prescaler restarted", A_CNT, 32'h8000_0000);
    bus_write(A_CTRL, 32'h1);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R5 tick after full ratio", A_CNT, 32'h8000_0001);

    // R7: write-one ignored, set wins over clear
    bus_write(A_SR, 32'h1);
    expect_reg("R7 write one ignored", A_SR, 32'h1);
    bus_write(A_SR, 32'h0);
    bus_write(A_DIV, 32'd0);
    bus_write(A_REL, 32'd1);
    bus_write(A_CNT, 32'd1);
    bus_write(A_CTRL, 32'h1);
    bus_write(A_SR, 32'h0);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R7 set wins", A_SR, 32'h1);
    expect_reg("R11 tick after overflow", A_CNT, 32'h8000_0001);
    bus_write(A_SR, 32'h0000_FFFE);
    expect_reg("R7 upper bits zero", A_SR, 32'h0);

    // R8: counter register layout
    bus_write(A_CNT, 32'hFFFF_1234);
    expect_reg("R8 upper write ignored", A_CNT, 32'h0000_1234);
    bus_write(A_EGR, 32'h1);
    bus_write(A_CNT, 32'h0000_ABCD);
    expect_reg("R8 flag copy in bit 31", A_CNT, 32'h8000_ABCD);

    // R9: interrupt output
    check("R9 disabled", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'h1);
    check("R9 enabled and set", {31'h0, irq}, 32'h1);
    bus_write(A_SR, 32'h0);
    check("R9 cleared", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'hFFFF_FFFE);
    expect_reg("R10 ien bit0", A_IEN, 32'h0);

    // R11: priorities
    bus_write(A_REL, 32'd1000);
    bus_write(A_CTRL, 32'h1);
    bus_write(A_CNT, 32'd7);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R11 write beats tick", A_CNT, 32'd8);
    bus_write(A_CTRL, 32'h1);
    bus_write(A_EGR, 32'h1);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R11 forced update beats tick", A_CNT, 32'h8000_0001);

    // R10: map
    bus_write(A_CTRL, 32'hFFFF_FFF8);
    expect_reg("R10 ctrl width", A_CTRL, 32'h0);
    bus_write(A_CTRL, 32'h5);
    expect_reg("R10 ctrl readback", A_CTRL, 32'h5);
    bus_write(A_CTRL, 32'h0);
    expect_reg("R10 unmapped", A_GAP, 32'h0);
    bus_write(A_DIV, 32'h0003_0009);
    expect_reg("R10 div width", A_DIV, 32'h9);

    // random phase, checked each cycle against the model
    bus_write(A_DIV, 32'd1);
    bus_write(A_REL, 32'd5);
    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [7:0] a;
      logic [31:0] d, r;
      kind = $urandom % 10;
      a = addrs[$urandom % 8];
      if (kind < 4) begin
        idle(1);
      end else if (kind < 6) begin
        bus_read(a, r);
      end else begin
        case (a)
          A_CTRL: d = ($urandom % 8) | 32'h1;
          A_DIV:  d = $urandom % 4;
          A_REL:  d = $urandom % 8;
          A_CNT:  d = ($urandom % 8) | ($urandom & 32'h8000_0000);
          A_EGR:  d = $urandom % 2;
          A_IEN:  d = $urandom % 2;
          default: d = $urandom;
        endcase
        bus_write(a, d);
      end
    end
    idle(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule